// File: doc/BRIEF.md
# SD card clock prescaler divider

This block derives the card clock for an SD or MMC host from a faster base clock. The divide ratio comes from two cascaded stages. The first is a prescaler selected by a one-hot code: all-zero bypasses it, and any single set bit selects a power of two. The second is a linear divisor whose factor is its field value plus one. The total ratio in base cycles is the product of the two factors. Software hands both fields over through a write strobe. A legal pair is stored as the pending setting. An illegal pair raises a flag and is dropped, and the previous setting stays in force.

The output is produced by a phase counter that runs on the base clock. A new setting is adopted only when the card clock falls, so neither phase is ever cut short. A clock-enable input lets the clock stop. The output then stays low at the end of the low phase that is under way. When the enable returns, the output starts again with a full high phase. A one-cycle pulse marks every rising edge of the card clock.

Top module: `cardclk_gen`

## Requirements
- R1: The card clock period, in base clock cycles, is the prescale factor times the divisor factor. The divisor factor is the 4-bit divisor field plus one. For example, prescale 0x08 with divisor 0xE gives 240, and prescale 0x01 with divisor 0x1 gives 4.
- R2: A prescale field of 0x00 gives a factor of 1. A field with only bit i set (i = 0..7) gives a factor of 2^(i+1), so 0x01 gives 2 and 0x80 gives 256.
- R3: A write whose prescale field has two or more bits set sets bad_setting to 1 on the cycle after the write. The card clock keeps running at the previously stored setting.
- R4: A write with both fields zero sets bad_setting to 1 on the cycle after the write. The previous setting stays in force.
- R5: After reset, card_clk, rise_pulse and bad_setting are 0. The stored setting is prescale 0x80 with divisor 0x0, which is a period of 256.
- R6: For a total ratio N, each high phase lasts floor(N/2) base cycles and each low phase lasts N − floor(N/2) base cycles.
- R7: A setting written while card_clk is high does not change the length of that high phase. The new setting first governs the low phase that follows the next falling edge.
- R8: While run_en is 0, card_clk stays low once the current low phase has ended, and no rise_pulse occurs. Once run_en returns to 1, card_clk rises on the next base clock edge and the high phase that follows has its full length.
- R9: rise_pulse is 1 for exactly one base cycle, the cycle in which card_clk has just changed from 0 to 1. It is therefore asserted once per card clock period.
- R10: A legal write sets bad_setting back to 0 on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Strobe that presents a new setting |
| wr_pre | input | 8 | Prescale code, one-hot or zero |
| wr_div | input | 4 | Divisor field, factor is value plus one |
| run_en | input | 1 | Clock enable for the card clock |
| card_clk | output | 1 | Divided card clock |
| bad_setting | output | 1 | Last write was rejected as illegal |
| rise_pulse | output | 1 | One-cycle marker of each card clock rising edge |

## Verification
The hardest case to reach from the ports is a write that lands inside a high phase. The old high length has to survive, and the new length must appear from the next low phase onward. The bench waits on rise_pulse and issues the write in the very next cycle. It then counts how long the high phase lasts, switching from a ratio of 32 to a ratio of 2. Stopping and restarting the clock is covered in a similar way. The bench drops run_en, watches for a long window that the output stays low, and then checks that the output rises one cycle after run_en returns. Random legal and illegal writes with a fixed seed cover the rest of the code space.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  // Total base-cycle ratio for a prescale code and divisor field.
  // Used only to build reset constants at elaboration.
  function automatic int unsigned total_ratio(input int unsigned pre_code,
                                              input int unsigned div_code,
                                              input int unsigned pre_w);
    int unsigned fac;
    fac = 1;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(pre_w) && pre_code[i]) fac = 2 << i;
    end
    return fac * (div_code + 1);
  endfunction

endpackage

// File: rtl/cardclk_check.sv
module cardclk_check #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4
) (
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] div,
  output logic             legal
);
  logic multi_hot;
  logic all_zero;

  assign multi_hot = ($countones(pre) > 1);
  assign all_zero  = (pre == '0) && (div == '0);
  assign legal     = !multi_hot && !all_zero;
endmodule

// File: rtl/cardclk_decode.sv
module cardclk_decode #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  parameter int LEN_W = PRE_W + DIV_W + 1
) (
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] div,
  output logic [LEN_W-1:0] hi_len,
  output logic [LEN_W-1:0] lo_len
);
  localparam int SH_W = $clog2(PRE_W + 2);

  logic [SH_W-1:0] sh_term [PRE_W];
  logic [SH_W-1:0] shift;
  logic [LEN_W-1:0] total;

  // each one-hot bit contributes its own shift amount
  for (genvar i = 0; i < PRE_W; i++) begin : g_term
    assign sh_term[i] = pre[i] ? SH_W'(i + 1) : '0;
  end

  always_comb begin
    shift = '0;
    for (int i = 0; i < PRE_W; i++) shift = shift | sh_term[i];
  end

  assign total  = (LEN_W'(div) + LEN_W'(1)) << shift;
  assign hi_len = total >> 1;
  assign lo_len = total - hi_len;
endmodule

// File: rtl/cardclk_setreg.sv
module cardclk_setreg #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  parameter logic [PRE_W-1:0] RESET_PRE = 8'h80,
  parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PRE_W-1:0] wr_pre,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_legal,
  output logic [PRE_W-1:0] pend_pre,
  output logic [DIV_W-1:0] pend_div,
  output logic             bad_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pre <= RESET_PRE;
      pend_div <= RESET_DIV;
      bad_flag <= 1'b0;
    end else if (wr_en) begin
      bad_flag <= !wr_legal;
      if (wr_legal) begin
        pend_pre <= wr_pre;
        pend_div <= wr_div;
      end
    end
  end

  // R3 / R4: a rejected write leaves the stored setting untouched
  p_keep_on_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_legal) |=> ($stable(pend_pre) && $stable(pend_div)));

  // R4 / R10: the flag reports the legality of the latest write
  p_flag_tracks_write_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (bad_flag == !$past(wr_legal)));

  // R10: the flag only moves on a write
  p_flag_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bad_flag));
endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase #(
  parameter int LEN_W = 13,
  parameter logic [LEN_W-1:0] RST_HI = 128,
  parameter logic [LEN_W-1:0] RST_LO = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [LEN_W-1:0] pend_hi,
  input  logic [LEN_W-1:0] pend_lo,
  output logic             clk_out,
  output logic             rise_out
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] act_hi;
  logic [LEN_W-1:0] act_lo;
  logic             hi_done;
  logic             lo_done;

  assign hi_done = (cnt >= act_hi - LEN_W'(1));
  assign lo_done = (cnt >= act_lo - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out  <= 1'b0;
      rise_out <= 1'b0;
      cnt      <= '0;
      act_hi   <= RST_HI;
      act_lo   <= RST_LO;
    end else begin
      rise_out <= 1'b0;
      if (clk_out) begin
        if (hi_done) begin
          clk_out <= 1'b0;
          cnt     <= '0;
          act_hi  <= pend_hi;
          act_lo  <= pend_lo;
        end else begin
          cnt <= cnt + LEN_W'(1);
        end
      end else if (lo_done) begin
        if (run_en) begin
          clk_out  <= 1'b1;
          rise_out <= 1'b1;
          cnt      <= '0;
        end else begin
          act_hi <= pend_hi;
          act_lo <= pend_lo;
        end
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end

  // R9: the marker coincides with a fresh 0 -> 1 step of the clock
  p_rise_marks_edge_r9: assert property (@(posedge clk) disable iff (rst)
    rise_out == (clk_out && !$past(clk_out)));

  // R8: with the enable low, a low output never rises
  p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!clk_out && !run_en) |=> !clk_out);

  // R7: the active lengths change only while the output is low
  p_apply_when_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_hi) || !$stable(act_lo)) |-> !clk_out);

  // R6: a high phase ends after exactly its programmed length
  p_high_length_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out) |-> ($past(cnt) == $past(act_hi) - LEN_W'(1)));
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  parameter logic [PRE_W-1:0] RESET_PRE = 8'h80,
  parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PRE_W-1:0] wr_pre,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             run_en,
  output logic             card_clk,
  output logic             bad_setting,
  output logic             rise_pulse
);
  import cardclk_pkg::*;

  localparam int LEN_W = PRE_W + DIV_W + 1;
  localparam int unsigned RST_N = total_ratio(RESET_PRE, RESET_DIV, PRE_W);
  localparam logic [LEN_W-1:0] RST_HI = LEN_W'(RST_N / 2);
  localparam logic [LEN_W-1:0] RST_LO = LEN_W'(RST_N - RST_N / 2);

  logic             wr_legal;
  logic             pend_legal;
  logic [PRE_W-1:0] pend_pre;
  logic [DIV_W-1:0] pend_div;
  logic [LEN_W-1:0] pend_hi;
  logic [LEN_W-1:0] pend_lo;

  cardclk_check #(.PRE_W(PRE_W), .DIV_W(DIV_W)) i_wr_check (
    .pre(wr_pre), .div(wr_div), .legal(wr_legal)
  );

  cardclk_setreg #(
    .PRE_W(PRE_W), .DIV_W(DIV_W), .RESET_PRE(RESET_PRE), .RESET_DIV(RESET_DIV)
  ) i_setreg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pre(wr_pre), .wr_div(wr_div),
    .wr_legal(wr_legal), .pend_pre(pend_pre), .pend_div(pend_div),
    .bad_flag(bad_setting)
  );

  cardclk_check #(.PRE_W(PRE_W), .DIV_W(DIV_W)) i_pend_check (
    .pre(pend_pre), .div(pend_div), .legal(pend_legal)
  );

  cardclk_decode #(.PRE_W(PRE_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) i_decode (
    .pre(pend_pre), .div(pend_div), .hi_len(pend_hi), .lo_len(pend_lo)
  );

  cardclk_phase #(.LEN_W(LEN_W), .RST_HI(RST_HI), .RST_LO(RST_LO)) i_phase (
    .clk(clk), .rst(rst), .run_en(run_en), .pend_hi(pend_hi),
    .pend_lo(pend_lo), .clk_out(card_clk), .rise_out(rise_pulse)
  );

  // R3 / R4: the stored setting is always a legal one
  p_stored_legal_r3: assert property (@(posedge clk) disable iff (rst)
    pend_legal);
endmodule

// File: tb/test_cardclk_gen.sv
module test_cardclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_pre = '0;
  logic [3:0] wr_div = '0;
  logic       run_en = 1'b1;
  logic       card_clk;
  logic       bad_setting;
  logic       rise_pulse;

  int checks = 0;
  int errors = 0;
  int cur_hi = 128;
  int cur_lo = 128;

  always #2 clk = ~clk;

  cardclk_gen i_cardclk_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pre(wr_pre), .wr_div(wr_div),
    .run_en(run_en), .card_clk(card_clk), .bad_setting(bad_setting),
    .rise_pulse(rise_pulse)
  );

  function automatic int exp_ratio(input logic [7:0] p, input logic [3:0] d);
    int f = 1;
    for (int i = 0; i < 8; i++) if (p[i]) f = 2 << i;
    return f * (int'(d) + 1);
  endfunction

  function automatic bit exp_legal(input logic [7:0] p, input logic [3:0] d);
    return ($countones(p) <= 1) && !(p == 0 && d == 0);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] p, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_pre = p; wr_div = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo, output int pulses);
    @(negedge clk);
    while (!rise_pulse) @(negedge clk);
    hi = 0; lo = 0; pulses = 0;
    while (card_clk) begin hi++; if (rise_pulse) pulses++; @(negedge clk); end
    while (!card_clk) begin lo++; if (rise_pulse) pulses++; @(negedge clk); end
  endtask

  task automatic program_and_check(input logic [7:0] p, input logic [3:0] d,
                                   input string req);
    int hi, lo, pu, n;
    n = exp_ratio(p, d);
    write(p, d);
    check(bad_setting == 1'b0, {req, " flag after legal write (R10)"}, bad_setting, 0);
    measure(hi, lo, pu);
    measure(hi, lo, pu);
    check(hi + lo == n, {req, " period (R1)"}, hi + lo, n);
    check(hi == n / 2 && lo == n - n / 2, {req, " duty (R6)"}, hi, n / 2);
    check(pu == 1, {req, " one rise marker per period (R9)"}, pu, 1);
    cur_hi = n / 2; cur_lo = n - n / 2;
  endtask

  task automatic reject_and_check(input logic [7:0] p, input logic [3:0] d,
                                  input string req);
    int hi, lo, pu;
    write(p, d);
    check(bad_setting == 1'b1, {req, " flag on illegal write"}, bad_setting, 1);
    measure(hi, lo, pu);
    measure(hi, lo, pu);
    check(hi == cur_hi && lo == cur_lo, {req, " old setting kept"}, hi + lo, cur_hi + cur_lo);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int hi, lo, pu, bad_cnt;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 reset state and default ratio
    check(card_clk == 0 && rise_pulse == 0, "R5 outputs low after reset", card_clk, 0);
    check(bad_setting == 0, "R5 flag clear after reset", bad_setting, 0);
    measure(hi, lo, pu);
    check(hi == 128 && lo == 128, "R5 default ratio 256 (R2 code 0x80)", hi + lo, 256);

    // directed ratios
    program_and_check(8'h08, 4'hE, "R1 240");
    program_and_check(8'h01, 4'h1, "R1 4");
    program_and_check(8'h00, 4'h4, "R2 bypass odd 5");
    program_and_check(8'h00, 4'h1, "R2 bypass 2");
    program_and_check(8'h80, 4'hF, "R2 maximum 4096");
    program_and_check(8'h02, 4'h2, "R6 odd-free 12");

    // illegal writes
    reject_and_check(8'h03, 4'h2, "R3 two bits");
    reject_and_check(8'hFF, 4'h0, "R3 all bits");
    reject_and_check(8'h00, 4'h0, "R4 both zero");
    program_and_check(8'h00, 4'h2, "R10 legal after reject");

    // R7: write during a high phase
    program_and_check(8'h04, 4'h3, "R7 setup 32");
    @(negedge clk);
    while (!rise_pulse) @(negedge clk);
    hi = 1; lo = 0;
    wr_en = 1'b1; wr_pre = 8'h00; wr_div = 4'h1;
    @(negedge clk);
    wr_en = 1'b0;
    while (card_clk) begin hi++; @(negedge clk); end
    while (!card_clk) begin lo++; @(negedge clk); end
    check(hi == 16, "R7 high phase in progress keeps old length", hi, 16);
    check(lo == 1, "R7 next low phase uses new length", lo, 1);
    cur_hi = 1; cur_lo = 1;

    // R8: stop and restart
    program_and_check(8'h01, 4'h1, "R8 setup 4");
    @(negedge clk);
    run_en = 1'b0;
    repeat (20) @(negedge clk);
    bad_cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (card_clk || rise_pulse) bad_cnt++;
      @(negedge clk);
    end
    check(bad_cnt == 0, "R8 output held low while disabled", bad_cnt, 0);
    run_en = 1'b1;
    @(negedge clk);
    check(card_clk == 1 && rise_pulse == 1, "R8 restart one cycle after enable (R9)", card_clk, 1);
    hi = 1;
    @(negedge clk);
    while (card_clk) begin hi++; @(negedge clk); end
    check(hi == 2, "R8 full high phase on restart", hi, 2);

    // random mix
    for (int it = 0; it < 16; it++) begin
      int r, idx, a, b;
      logic [7:0] p;
      logic [3:0] d;
      r = $urandom % 10;
      if (r < 7) begin
        idx = $urandom % 7;
        p = (idx == 6) ? 8'h00 : 8'(1 << idx);
        d = 4'($urandom % 16);
        if (p == 0 && d == 0) d = 4'h3;
        program_and_check(p, d, "R1 random legal");
      end else begin
        a = $urandom % 8;
        b = (a + 1 + ($urandom % 7)) % 8;
        p = 8'(1 << a) | 8'(1 << b);
        d = 4'($urandom % 16);
        if (exp_legal(p, d)) p = 8'h11;
        reject_and_check(p, d, "R3 random illegal");
      end
    end
    finish_run();
  end
endmodule